// File: doc/BRIEF.md
# Receiver Frame Identifier Matcher

This block sits in a serial receive path after bit-clock recovery. It watches a stream of recovered data bits, each qualified by a valid strobe. It compares the most recent bits against a programmable identifier word, and a 2-bit field sets how many bits of that word take part. A window equal to the identifier, or to its bitwise complement, counts as a detection. The block then raises a one-cycle detect pulse and records which polarity matched. It then leaves identifier search for a header-search phase, which a later stage carries out.

Searching starts only after the clock-recovery stage reports completion. A synchronous restart input returns the block to idle and forgets every bit received so far. This input is used when bit lock is lost or a frame ends. When the receiver runs duty-cycled, the block drives a stay-awake flag once the identifier has been found, so the receiver does not return to its off period in the middle of a frame.

Top module: `frame_id_matcher`

## Requirements
- R1: After reset, `id_searching`, `id_found`, `id_inverted`, `hdr_search` and `stay_awake` are all 0.
- R2: Bits presented while the block is idle are ignored. The block enters search in the cycle after the clock edge that samples `recov_done` high, and `id_searching` shows that phase.
- R3: `id_len` codes 00, 01, 10 and 11 select 8, 16, 24 and 32 compared bits. Bits enter most significant first: the earliest bit of the window lines up with bit L-1 of `id_word`, and the latest bit lines up with bit 0. Bits of `id_word` at or above L are ignored.
- R4: No detection occurs until at least L valid bits have been taken since search began.
- R5: A window equal to the bitwise complement of the low L bits of `id_word` is detected, and `id_inverted` is then 1.
- R6: A window equal to the low L bits of `id_word` is detected with `id_inverted` 0. `id_inverted` holds its value through the header phase until restart.
- R7: `id_found` is high for exactly one cycle: the cycle after the clock edge that takes the final matching bit. In that same cycle `hdr_search` rises and `id_searching` falls. After that, further bits cause no detection.
- R8: `stay_awake` is high exactly when `strobe_mode` is 1 and the block is in the header phase.
- R9: While `restart` is sampled high, the block goes to idle on the next cycle, clears its outputs and its bit count, and needs `recov_done` before it searches again.
- R10: An identifier of all zeros or all ones is detected by a constant bit stream of either level, through the true match or the complement match.
- R11: A cycle with `bit_valid` low neither shifts nor counts `bit_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to idle, clears the bit count |
| recov_done | input | 1 | Clock recovery complete; starts the search |
| strobe_mode | input | 1 | Receiver is running duty-cycled |
| bit_valid | input | 1 | Qualifies `bit_data` for this cycle |
| bit_data | input | 1 | Recovered data bit |
| id_word | input | 32 | Programmed identifier, low bits used |
| id_len | input | 2 | Identifier length code |
| id_searching | output | 1 | Identifier search in progress |
| id_found | output | 1 | One-cycle detect pulse |
| id_inverted | output | 1 | Detected identifier was the complement |
| hdr_search | output | 1 | Header-search phase active |
| stay_awake | output | 1 | Keep the duty-cycled receiver in run mode |

## Verification
The hardest case to reach from the ports is a restart in the middle of a search that leaves a partial bit count behind. If that count survived the restart, the block would report a detection too early. With most identifiers, the stale count hides behind a window mismatch, so the fault stays unseen. The stimulus therefore uses an all-zero identifier, where the cleared window already equals the pattern and only the count prevents a detection. It sends five zeros, restarts, sends three more, and expects a detection only on the eighth zero after the restart.

// File: rtl/frame_id_pkg.sv
package frame_id_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_HEADER = 2'd2
  } fid_state_e;
endpackage

// File: rtl/fid_shifter.sv
module fid_shifter #(
  parameter int ID_MAX = 32,
  localparam int CNT_W = $clog2(ID_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [ID_MAX-1:0] win_next,
  output logic [CNT_W-1:0]  cnt_next,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [ID_MAX-1:0] win_q;
  logic [ID_MAX-1:0] win_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              reg_en;

  // window and count as they stand once the current bit is taken
  assign win_next = {win_q[ID_MAX-2:0], bit_in};
  assign cnt_next = (cnt_q == CNT_W'(ID_MAX)) ? cnt_q : cnt_q + 1'b1;
  assign reg_en   = clear | shift_en;

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (clear) begin
      win_d = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      win_d = win_next;
      cnt_d = cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end

  // the count never passes the window width
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ID_MAX));

  // a cycle without a valid bit leaves the count alone
  assert_hold_idle_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !shift_en) |=> $stable(cnt_q));
endmodule

// File: rtl/fid_compare.sv
module fid_compare #(
  parameter int ID_MAX   = 32,
  parameter int LEN_STEP = 8,
  parameter int LEN_W    = 2,
  localparam int CNT_W   = $clog2(ID_MAX + 1)
) (
  input  logic [ID_MAX-1:0] window,
  input  logic [CNT_W-1:0]  count,
  input  logic [ID_MAX-1:0] id_word,
  input  logic [LEN_W-1:0]  id_len,
  output logic              hit_true,
  output logic              hit_inv
);
  logic [CNT_W-1:0]  len_sel;
  logic [ID_MAX-1:0] mask;
  logic [ID_MAX-1:0] diff_true;
  logic [ID_MAX-1:0] diff_inv;
  logic              full;

  assign len_sel = CNT_W'((int'(id_len) + 1) * LEN_STEP);

  for (genvar gi = 0; gi < ID_MAX; gi++) begin : g_mask
    assign mask[gi] = (CNT_W'(gi) < len_sel);
  end

  assign diff_true = (window ^  id_word) & mask;
  assign diff_inv  = (window ^ ~id_word) & mask;
  assign full      = (count >= len_sel);

  always_comb begin
    hit_true = full && (diff_true == '0);
    // the true polarity takes precedence
    hit_inv  = full && (diff_inv == '0) && !hit_true;
  end
endmodule

// File: rtl/frame_id_matcher.sv
module frame_id_matcher #(
  parameter int ID_MAX   = 32,
  parameter int LEN_STEP = 8,
  parameter int LEN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              recov_done,
  input  logic              strobe_mode,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic [ID_MAX-1:0] id_word,
  input  logic [LEN_W-1:0]  id_len,
  output logic              id_searching,
  output logic              id_found,
  output logic              id_inverted,
  output logic              hdr_search,
  output logic              stay_awake
);
  import frame_id_pkg::*;

  localparam int CNT_W = $clog2(ID_MAX + 1);

  fid_state_e        state_q, state_d;
  logic              found_q, found_d;
  logic              inv_q, inv_d;
  logic              sh_clear, sh_en;
  logic [ID_MAX-1:0] win_next;
  logic [CNT_W-1:0]  cnt_next, cnt_q;
  logic              hit_true, hit_inv;

  assign sh_clear = restart || (state_q != ST_SEARCH);
  assign sh_en    = (state_q == ST_SEARCH) && bit_valid;

  fid_shifter #(.ID_MAX(ID_MAX)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sh_clear),
    .shift_en (sh_en),
    .bit_in   (bit_data),
    .win_next (win_next),
    .cnt_next (cnt_next),
    .cnt_q    (cnt_q)
  );

  fid_compare #(.ID_MAX(ID_MAX), .LEN_STEP(LEN_STEP), .LEN_W(LEN_W)) u_cmp (
    .window   (win_next),
    .count    (cnt_next),
    .id_word  (id_word),
    .id_len   (id_len),
    .hit_true (hit_true),
    .hit_inv  (hit_inv)
  );

  always_comb begin
    state_d = state_q;
    found_d = 1'b0;
    inv_d   = inv_q;
    if (restart) begin
      state_d = ST_IDLE;
      inv_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (recov_done) state_d = ST_SEARCH;
        ST_SEARCH: begin
          if (bit_valid && (hit_true || hit_inv)) begin
            state_d = ST_HEADER;
            found_d = 1'b1;
            inv_d   = hit_inv;
          end
        end
        ST_HEADER: state_d = ST_HEADER;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      found_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      found_q <= found_d;
      inv_q   <= inv_d;
    end
  end

  assign id_searching = (state_q == ST_SEARCH);
  assign hdr_search   = (state_q == ST_HEADER);
  assign id_found     = found_q;
  assign id_inverted  = inv_q;
  assign stay_awake   = strobe_mode && hdr_search;

  // bits needed for the length field, used by the checks below
  logic [CNT_W-1:0] need_bits;
  assign need_bits = CNT_W'((int'(id_len) + 1) * LEN_STEP);

  assert_found_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_found |=> !id_found);

  assert_found_enters_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_search && !$past(hdr_search)) |-> id_found);

  assert_no_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    id_found |-> ($past(bit_valid) && ($past(cnt_next) >= $past(need_bits))));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_searching && !hdr_search) |=> !id_found);

  assert_restart_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!hdr_search && !id_found && !id_searching && !id_inverted));

  assert_inv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_search && !id_found) |-> $stable(id_inverted));
endmodule

// File: tb/frame_id_matcher_test.sv
module frame_id_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart, recov_done, strobe_mode, bit_valid, bit_data;
  logic [31:0] id_word;
  logic [1:0]  id_len;
  logic        id_searching, id_found, id_inverted, hdr_search, stay_awake;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic  found;
    logic  inv;
    logic  hdr;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  frame_id_matcher uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .recov_done(recov_done),
    .strobe_mode(strobe_mode), .bit_valid(bit_valid), .bit_data(bit_data),
    .id_word(id_word), .id_len(id_len), .id_searching(id_searching),
    .id_found(id_found), .id_inverted(id_inverted), .hdr_search(hdr_search),
    .stay_awake(stay_awake)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: one valid bit per call, expectation pushed for the monitor
  task automatic send_bit(input logic b, input logic ef, input logic ei,
                          input logic eh, input string tag);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
    exp_q.push_back('{ef, ei, eh, tag});
  endtask

  task automatic stop_bits();
    @(negedge clk);
    bit_valid = 1'b0;
    bit_data  = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input logic hit,
                           input logic inv, input logic pre_hdr, input logic pre_inv,
                           input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      logic last;
      last = (i == 0);
      send_bit(w[i], hit && last, (hit && last) ? inv : pre_inv,
               pre_hdr || (hit && last), tag);
    end
    stop_bits();
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(hdr_search, 1'b0, "R9 hdr_search after restart");
    check(id_searching, 1'b0, "R9 idle after restart");
    check(id_inverted, 1'b0, "R9 inverted cleared");
    @(negedge clk);
  endtask

  // monitor: compare outputs in the cycle after each taken bit
  initial begin
    forever begin
      @(posedge clk);
      if (bit_valid === 1'b1) begin
        exp_t e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: actual result with no expected item, expected none");
        end else begin
          e = exp_q.pop_front();
          check(id_found, e.found, {e.tag, " found"});
          check(id_inverted, e.inv, {e.tag, " inverted"});
          check(hdr_search, e.hdr, {e.tag, " hdr_search"});
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; recov_done = 1'b0; strobe_mode = 1'b1;
    bit_valid = 1'b0; bit_data = 1'b0; id_word = 32'hFFFF_FFA5; id_len = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(id_searching, 1'b0, "R1 searching");
    check(id_found, 1'b0, "R1 found");
    check(id_inverted, 1'b0, "R1 inverted");
    check(hdr_search, 1'b0, "R1 hdr_search");
    check(stay_awake, 1'b0, "R1 stay_awake");
    rst_n = 1'b1;

    // R2: identifier sent while idle is ignored
    send_word(32'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle bits");
    check(id_searching, 1'b0, "R2 still idle");
    recov_done = 1'b1;
    @(negedge clk);
    check(id_searching, 1'b1, "R2 search entered");
    // R6/R3 true match on low byte, upper register bits ignored
    send_word(32'hA5, 8, 1'b1, 1'b0, 1'b0, 1'b0, "R6 true match");
    check(id_searching, 1'b0, "R7 search left");
    // R8 stay-awake follows strobed mode in header phase
    check(stay_awake, 1'b1, "R8 awake strobed");
    strobe_mode = 1'b0; #1;
    check(stay_awake, 1'b0, "R8 not strobed");
    strobe_mode = 1'b1;
    // R7 further bits in header phase are ignored
    send_word(32'hA5, 8, 1'b0, 1'b0, 1'b1, 1'b0, "R7 header ignores");
    do_restart();

    // R5 complement match
    send_word(32'h5A, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R5 complement");
    check(id_inverted, 1'b1, "R6 inverted held");
    do_restart();

    // R4/R10 all-zero identifier: cleared window matches, only count guards
    id_word = 32'h0000_0000;
    send_word(32'h0, 8, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R10 zero tone");
    do_restart();
    // R10 all-ones identifier detected by zero tone via complement
    id_word = 32'hFFFF_FFFF;
    send_word(32'h0, 8, 1'b1, 1'b1, 1'b0, 1'b0, "R10 ones id zero tone");
    do_restart();

    // R3 16-bit length
    id_word = 32'hFFFF_3C69; id_len = 2'b01;
    send_word(32'h3C69, 16, 1'b1, 1'b0, 1'b0, 1'b0, "R3 len16");
    do_restart();
    // R3 32-bit length with a leading prefix
    id_word = 32'h1234_5678; id_len = 2'b11;
    send_word(32'hA, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R3 prefix");
    send_word(32'h1234_5678, 32, 1'b1, 1'b0, 1'b0, 1'b0, "R3 len32");
    do_restart();

    // R11 gaps with bit_valid low and toggling data
    id_word = 32'h0000_00A5; id_len = 2'b00;
    send_word(32'hA, 4, 1'b0, 1'b0, 1'b0, 1'b0, "R11 first half");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      bit_valid = 1'b0; bit_data = k[0];
    end
    check(hdr_search, 1'b0, "R11 no detect in gap");
    send_word(32'h5, 4, 1'b1, 1'b0, 1'b0, 1'b0, "R11 second half");
    do_restart();

    // R9 restart mid-search clears the bit count
    id_word = 32'h0;
    send_word(32'h0, 5, 1'b0, 1'b0, 1'b0, 1'b0, "R9 partial");
    do_restart();
    send_word(32'h0, 3, 1'b0, 1'b0, 1'b0, 1'b0, "R9 count cleared");
    send_word(32'h0, 5, 1'b1, 1'b0, 1'b0, 1'b0, "R9 full after restart");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule